// File: doc/BRIEF.md
# Round-Robin Job Scheduler with Quantum Context Switching

This block time-slices one processor core among a small fixed set of jobs. Before the run begins, jobs are registered one at a time by program length. Each accepted job receives the next job number and a memory window that starts at the first free word after the jobs already placed. Its saved accumulator and program counter start at zero. A start pulse hands the first job in load order to the core. From then on the block counts retired instructions against a programmable quantum.

When the quantum is used up, the block asks the core for the live accumulator and program counter. It stores them in that job's context slot and puts the job at the back of a first-in first-out ready queue. It then takes the job at the front of the queue and offers that job's accumulator, program counter, window base and window limit to the core for one cycle. When a job halts or faults, the core pulses a termination input. That job is discarded without any save, and the next queued job is restored at once. If no jobs remain, the block stops for good and raises a finished flag.

The controller has five states. LOAD collects jobs. PICK pops the queue head and presents its context. RUN counts instructions. SAVE waits for the core's save acknowledge. DONE is final. The transitions are: LOAD to PICK on start when at least one job exists, and LOAD to DONE on start with none. PICK always moves to RUN. RUN moves to PICK on termination when the queue is non-empty, to DONE on termination when the queue is empty, and to SAVE on quantum expiry. SAVE moves to PICK on acknowledge. DONE stays where it is.

Top module: `rr_job_sched`

## Requirements
- R1: In LOAD, a load request of length L that is accepted creates a job. Its number equals the count of jobs accepted before it. Its base equals the sum of the earlier accepted lengths, its limit equals base + L, and its saved accumulator and program counter are zero. `load_ok` is high for exactly the cycle after the request.
- R2: A load is rejected when base + L is 512 or more, or when NJOBS jobs already exist. A rejected load creates no job, leaves the next free base unchanged, and gives no `load_ok`.
- R3: `start` in LOAD with at least one job gives `ctx_valid` in the next cycle with job 0's context, then `running` with `cur_job` = 0. Before start, nothing is running or offered. `start` with no jobs goes straight to DONE.
- R4: In RUN, each `retire` counts one instruction. The retire that brings the count to the quantum or above ends RUN, and `save_req` is high from the next cycle.
- R5: `save_req` holds until `save_ack`. At the acknowledging edge, `save_acc` and `save_pc` become that job's saved context, and the job goes to the tail of the ready queue. The values are returned when the job is next restored.
- R6: In PICK, the job at the queue head is removed and becomes `cur_job`. Its accumulator, program counter, base and limit appear on the `ctx_*` outputs with `ctx_valid` high for one cycle. `running` follows in the next cycle, with the instruction count restarted from zero.
- R7: `term` in RUN drops the current job with no save request. If the queue is non-empty, PICK follows in the next cycle. Otherwise `all_done` rises and stays high.
- R8: When `term` and `retire` arrive in the same RUN cycle, termination wins and the retire is not counted.
- R9: `retire` and `term` outside RUN, and `load_valid` and `start` outside LOAD, have no effect.
- R10: A quantum input of zero behaves as a quantum of one, so every retire ends the slice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| quantum | input | QW | Instructions per time slice (0 means 1) |
| load_valid | input | 1 | Register one job of length `load_len` |
| load_len | input | ADDR_W | Program length in words |
| load_ok | output | 1 | Previous cycle's load was accepted |
| start | input | 1 | End loading and dispatch the first job |
| retire | input | 1 | Core retired one instruction |
| term | input | 1 | Current job halted or faulted |
| save_req | output | 1 | Core must return its live state |
| save_ack | input | 1 | `save_acc`/`save_pc` are valid |
| save_acc | input | DATA_W | Live accumulator of the current job |
| save_pc | input | ADDR_W | Live program counter of the current job |
| ctx_valid | output | 1 | Restore context is on the `ctx_*` outputs |
| ctx_acc | output | DATA_W | Accumulator to restore |
| ctx_pc | output | ADDR_W | Program counter to restore |
| ctx_base | output | ADDR_W | Memory window base to restore |
| ctx_limit | output | ADDR_W | Memory window limit to restore |
| running | output | 1 | Core may execute the current job |
| cur_job | output | ID_W | Number of the current job |
| all_done | output | 1 | Every job has terminated |

## Verification
Each result has a fixed latency from the edge that samples its cause. `load_ok` is due one cycle after a load request, as is `save_req` after the expiring retire. `ctx_valid` is due one cycle after `start`, after a termination with jobs still queued, or after a save acknowledge. `running` and the new `cur_job` follow one cycle after `ctx_valid`. The bench drives inputs on the falling edge and updates a queue-based model on the rising edge. It then compares every output against that model on the next falling edge, so each expectation is taken exactly in the cycle where the registered state has moved.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic [2:0] {
        ST_LOAD,
        ST_PICK,
        ST_RUN,
        ST_SAVE,
        ST_DONE
    } sched_state_e;
endpackage

// File: rtl/rrs_id_fifo.sv
module rrs_id_fifo #(
    parameter int DEPTH = 4,
    parameter int ID_W  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    output logic [ID_W-1:0] head_id,
    output logic            empty,
    output logic            full
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [ID_W-1:0]  slot_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    assign head_id = slot_q[rd_q];
    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == FULL_CNT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
            for (int k = 0; k < DEPTH; k++) slot_q[k] <= '0;
        end else begin
            if (push) begin
                slot_q[wr_q] <= push_id;
                wr_q         <= step(wr_q);
            end
            if (pop) rd_q <= step(rd_q);
            if (push && !pop)      cnt_q <= cnt_q + CNT_W'(1);
            else if (pop && !push) cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // R6
    fifo_over_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |-> pop);
    // R6
    fifo_under_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/rrs_ctx_bank.sv
module rrs_ctx_bank #(
    parameter int NJOBS  = 4,
    parameter int ID_W   = 2,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_we,
    input  logic [ID_W-1:0]   new_id,
    input  logic [ADDR_W-1:0] new_base,
    input  logic [ADDR_W-1:0] new_limit,
    input  logic              sv_we,
    input  logic [ID_W-1:0]   sv_id,
    input  logic [DATA_W-1:0] sv_acc,
    input  logic [ADDR_W-1:0] sv_pc,
    input  logic [ID_W-1:0]   rd_id,
    output logic [DATA_W-1:0] rd_acc,
    output logic [ADDR_W-1:0] rd_pc,
    output logic [ADDR_W-1:0] rd_base,
    output logic [ADDR_W-1:0] rd_limit
);
    logic [DATA_W-1:0] acc_q  [NJOBS];
    logic [ADDR_W-1:0] pc_q   [NJOBS];
    logic [ADDR_W-1:0] base_q [NJOBS];
    logic [ADDR_W-1:0] lim_q  [NJOBS];

    for (genvar j = 0; j < NJOBS; j++) begin : g_slot
        localparam logic [ID_W-1:0] MY_ID = ID_W'(j);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[j]  <= '0;
                pc_q[j]   <= '0;
                base_q[j] <= '0;
                lim_q[j]  <= '0;
            end else if (new_we && new_id == MY_ID) begin
                acc_q[j]  <= '0;
                pc_q[j]   <= '0;
                base_q[j] <= new_base;
                lim_q[j]  <= new_limit;
            end else if (sv_we && sv_id == MY_ID) begin
                acc_q[j]  <= sv_acc;
                pc_q[j]   <= sv_pc;
            end
        end

        // R1
        slot_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lim_q[j] >= base_q[j]);
    end

    assign rd_acc   = acc_q[rd_id];
    assign rd_pc    = pc_q[rd_id];
    assign rd_base  = base_q[rd_id];
    assign rd_limit = lim_q[rd_id];
endmodule

// File: rtl/rrs_quantum_ctr.sv
module rrs_quantum_ctr #(
    parameter int QW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          tick,
    input  logic [QW-1:0] quantum,
    output logic          expire
);
    logic [QW-1:0] cnt_q;
    logic [QW-1:0] q_eff;
    logic [QW:0]   cnt_nxt;

    assign q_eff   = (quantum == '0) ? QW'(1) : quantum;
    assign cnt_nxt = {1'b0, cnt_q} + (QW+1)'(1);
    assign expire  = tick && (cnt_nxt >= {1'b0, q_eff});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (clear || expire) cnt_q <= '0;
        else if (tick)            cnt_q <= cnt_nxt[QW-1:0];
    end
endmodule

// File: rtl/rr_job_sched.sv
module rr_job_sched #(
    parameter int NJOBS     = 4,
    parameter int MEM_WORDS = 512,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 16,
    parameter int QW        = 16,
    localparam int ID_W     = $clog2(NJOBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [QW-1:0]     quantum,
    input  logic              load_valid,
    input  logic [ADDR_W-1:0] load_len,
    output logic              load_ok,
    input  logic              start,
    input  logic              retire,
    input  logic              term,
    output logic              save_req,
    input  logic              save_ack,
    input  logic [DATA_W-1:0] save_acc,
    input  logic [ADDR_W-1:0] save_pc,
    output logic              ctx_valid,
    output logic [DATA_W-1:0] ctx_acc,
    output logic [ADDR_W-1:0] ctx_pc,
    output logic [ADDR_W-1:0] ctx_base,
    output logic [ADDR_W-1:0] ctx_limit,
    output logic              running,
    output logic [ID_W-1:0]   cur_job,
    output logic              all_done
);
    import rrs_pkg::*;

    localparam int CNT_W = $clog2(NJOBS + 1);
    localparam logic [CNT_W-1:0]  JOB_MAX = CNT_W'(NJOBS);
    localparam logic [ADDR_W:0]   MEM_END = (ADDR_W+1)'(MEM_WORDS);

    sched_state_e      state_q, state_d;
    logic [ID_W-1:0]   cur_q;
    logic [CNT_W-1:0]  jobs_q;
    logic [ADDR_W-1:0] free_q;
    logic              ok_q;

    logic [ADDR_W:0]   end_sum;
    logic              fits, load_acc;
    logic              q_push, q_pop, q_empty, q_full;
    logic [ID_W-1:0]   q_push_id, q_head;
    logic              tick, expire, sv_we;

    assign end_sum  = {1'b0, free_q} + {1'b0, load_len};
    assign fits     = (jobs_q < JOB_MAX) && (end_sum < MEM_END);
    assign load_acc = (state_q == ST_LOAD) && load_valid && !start && fits;
    assign sv_we    = (state_q == ST_SAVE) && save_ack;
    assign tick     = (state_q == ST_RUN) && retire && !term;

    assign q_push    = load_acc || sv_we;
    assign q_push_id = load_acc ? jobs_q[ID_W-1:0] : cur_q;
    assign q_pop     = (state_q == ST_PICK);

    rrs_id_fifo #(.DEPTH(NJOBS), .ID_W(ID_W)) i_queue (
        .clk(clk), .rst_n(rst_n),
        .push(q_push), .push_id(q_push_id), .pop(q_pop),
        .head_id(q_head), .empty(q_empty), .full(q_full)
    );

    rrs_ctx_bank #(.NJOBS(NJOBS), .ID_W(ID_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_bank (
        .clk(clk), .rst_n(rst_n),
        .new_we(load_acc), .new_id(jobs_q[ID_W-1:0]),
        .new_base(free_q), .new_limit(end_sum[ADDR_W-1:0]),
        .sv_we(sv_we), .sv_id(cur_q), .sv_acc(save_acc), .sv_pc(save_pc),
        .rd_id(q_head),
        .rd_acc(ctx_acc), .rd_pc(ctx_pc), .rd_base(ctx_base), .rd_limit(ctx_limit)
    );

    rrs_quantum_ctr #(.QW(QW)) i_quant (
        .clk(clk), .rst_n(rst_n),
        .clear(q_pop), .tick(tick), .quantum(quantum), .expire(expire)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD: if (start) state_d = (jobs_q != '0) ? ST_PICK : ST_DONE;
            ST_PICK: state_d = ST_RUN;
            ST_RUN: begin
                if (term)        state_d = q_empty ? ST_DONE : ST_PICK;
                else if (expire) state_d = ST_SAVE;
            end
            ST_SAVE: if (save_ack) state_d = ST_PICK;
            ST_DONE: state_d = ST_DONE;
            default: state_d = ST_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            cur_q   <= '0;
            jobs_q  <= '0;
            free_q  <= '0;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            ok_q    <= load_acc;
            if (load_acc) begin
                jobs_q <= jobs_q + CNT_W'(1);
                free_q <= end_sum[ADDR_W-1:0];
            end
            if (q_pop) cur_q <= q_head;
        end
    end

    always_comb begin
        load_ok   = ok_q;
        running   = (state_q == ST_RUN);
        save_req  = (state_q == ST_SAVE);
        ctx_valid = (state_q == ST_PICK);
        all_done  = (state_q == ST_DONE);
        cur_job   = cur_q;
    end

    // R2
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && load_valid && !start && end_sum >= MEM_END) |=> !load_ok);
    // R3
    start_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && start && jobs_q != '0) |=> ctx_valid);
    // R6
    pick_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_valid |=> running);
    // R5
    save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !save_ack) |=> save_req);
    // R7
    term_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && term) |=> (!running && !save_req));
    // R7
    done_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        all_done |=> all_done);
    // R10
    q_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && retire && !term && quantum == '0) |=> save_req);
endmodule

// File: tb/test_rr_job_sched.sv
`timescale 1ns/1ps
module test_rr_job_sched;
    localparam int NJ = 4;
    localparam int MEMW = 512;
    localparam int M_LOAD = 0, M_PICK = 1, M_RUN = 2, M_SAVE = 3, M_DONE = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] quantum = 16'd3;
    logic        load_valid = 1'b0;
    logic [15:0] load_len = '0;
    logic        start = 1'b0, retire = 1'b0, term = 1'b0, save_ack = 1'b0;
    logic [31:0] save_acc = '0;
    logic [15:0] save_pc = '0;
    logic        load_ok, save_req, ctx_valid, running, all_done;
    logic [31:0] ctx_acc;
    logic [15:0] ctx_pc, ctx_base, ctx_limit;
    logic [1:0]  cur_job;

    int total = 0, bad = 0;
    bit mon_en = 1'b0;

    // behavioural model
    int mst, mcur, mjobs, mnb, mcnt;
    bit mlok;
    int mq[$];
    longint macc[NJ], mpc[NJ], mbase[NJ], mlim[NJ];

    always #2.5 clk = ~clk;

    rr_job_sched i_rr_job_sched (
        .clk(clk), .rst_n(rst_n), .quantum(quantum),
        .load_valid(load_valid), .load_len(load_len), .load_ok(load_ok),
        .start(start), .retire(retire), .term(term),
        .save_req(save_req), .save_ack(save_ack), .save_acc(save_acc), .save_pc(save_pc),
        .ctx_valid(ctx_valid), .ctx_acc(ctx_acc), .ctx_pc(ctx_pc),
        .ctx_base(ctx_base), .ctx_limit(ctx_limit),
        .running(running), .cur_job(cur_job), .all_done(all_done)
    );

    task automatic chk(input bit ok, input string rq, input string nm,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", rq, nm, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin : model
        int qe;
        if (!rst_n) begin
            mst = M_LOAD; mq.delete(); mcur = 0; mjobs = 0; mnb = 0; mcnt = 0; mlok = 0;
        end else begin
            qe = (quantum == 0) ? 1 : int'(quantum);
            mlok = 0;
            case (mst)
                M_LOAD: begin
                    if (start) mst = (mjobs > 0) ? M_PICK : M_DONE;
                    else if (load_valid && mjobs < NJ && mnb + int'(load_len) < MEMW) begin
                        macc[mjobs] = 0; mpc[mjobs] = 0;
                        mbase[mjobs] = mnb; mlim[mjobs] = mnb + int'(load_len);
                        mq.push_back(mjobs); mjobs++; mnb += int'(load_len); mlok = 1;
                    end
                end
                M_PICK: begin mcur = mq.pop_front(); mcnt = 0; mst = M_RUN; end
                M_RUN: begin
                    if (term) mst = (mq.size() == 0) ? M_DONE : M_PICK;
                    else if (retire) begin
                        if (mcnt + 1 >= qe) begin mst = M_SAVE; mcnt = 0; end
                        else mcnt++;
                    end
                end
                M_SAVE: if (save_ack) begin
                    macc[mcur] = save_acc; mpc[mcur] = save_pc;
                    mq.push_back(mcur); mst = M_PICK;
                end
                default: ;
            endcase
        end
    end

    always @(negedge clk) if (mon_en) begin
        chk(load_ok === mlok, "R1", "load_ok", load_ok, mlok);
        // R10 tag applies while the quantum input is zero
        chk(save_req === (mst == M_SAVE), (quantum == 0) ? "R10" : "R4", "save_req",
            save_req, mst == M_SAVE);
        chk(ctx_valid === (mst == M_PICK), "R6", "ctx_valid", ctx_valid, mst == M_PICK);
        if (mst == M_PICK) begin
            chk(ctx_acc === macc[mq[0]][31:0], "R5", "ctx_acc", ctx_acc, macc[mq[0]]);
            chk(ctx_pc === mpc[mq[0]][15:0], "R5", "ctx_pc", ctx_pc, mpc[mq[0]]);
            chk(ctx_base === mbase[mq[0]][15:0], "R1", "ctx_base", ctx_base, mbase[mq[0]]);
            chk(ctx_limit === mlim[mq[0]][15:0], "R1", "ctx_limit", ctx_limit, mlim[mq[0]]);
        end
        // R8: a retire hidden by term would shift cur_job timing
        chk(cur_job === mcur[1:0], "R8", "cur_job", cur_job, mcur);
        // R9: stray retire/term/load/start must not move running
        chk(running === (mst == M_RUN), "R9", "running", running, mst == M_RUN);
        chk(all_done === (mst == M_DONE), "R7", "all_done", all_done, mst == M_DONE);
    end

    task automatic do_load(input int len, input bit exp_ok, input string rq);
        @(negedge clk); load_valid = 1'b1; load_len = 16'(len);
        @(negedge clk); load_valid = 1'b0;
        chk(load_ok === exp_ok, rq, "load result", load_ok, exp_ok);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        logic [31:0] lfsr;
        lfsr = 32'h1ace5eed;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: nothing dispatched before start
        chk(!running && !ctx_valid && !save_req && !all_done && !load_ok, "R3",
            "reset state", {running, ctx_valid, save_req, all_done, load_ok}, 0);
        mon_en = 1'b1;
        do_load(100, 1'b1, "R1");   // job0 [0,100)
        do_load(200, 1'b1, "R1");   // job1 [100,300)
        do_load(250, 1'b0, "R2");   // ends at 550
        do_load(211, 1'b1, "R1");   // job2 [300,511)
        do_load(1,   1'b0, "R2");   // would end exactly at 512
        do_load(0,   1'b1, "R1");   // job3 [511,511)
        do_load(0,   1'b0, "R2");   // all slots used
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(ctx_valid === 1'b1 && ctx_base === 16'd0 && ctx_limit === 16'd100, "R3",
            "first dispatch", {ctx_valid, ctx_base, ctx_limit}, {1'b1, 16'd0, 16'd100});
        for (int i = 0; i < 700; i++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            quantum    = (i < 250) ? 16'd3 : (i < 400) ? 16'd0 : 16'd5;
            retire     = lfsr[0] | lfsr[1];
            term       = (lfsr[9:5] == 5'd0) && (i > 40);
            save_ack   = (mst == M_SAVE) && lfsr[2];
            save_acc   = lfsr;
            save_pc    = lfsr[31:16] ^ 16'(i);
            load_valid = (i == 50);
            load_len   = 16'd5;
            start      = (i == 60);
        end
        for (int i = 0; i < 300 && mst != M_DONE; i++) begin
            @(negedge clk);
            retire = 1'b1; term = (mst == M_RUN); save_ack = 1'b1;
        end
        @(negedge clk); term = 1'b0; retire = 1'b0; save_ack = 1'b0;
        repeat (3) @(negedge clk);
        chk(all_done === 1'b1 && running === 1'b0, "R7", "final done",
            {all_done, running}, 2'b10);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule